// File: doc/BRIEF.md
# Vector element displacement generator

This block produces, for one element of a vector load or store, the displacement that the address adder uses in place of the instruction's own immediate. It sits between instruction decode and the address adder. Each request carries the raw immediate fields, the instruction format (plain 16-bit displacement or the 14-bit word-scaled variant), a two-bit addressing mode, the source and destination element steps, the access width in bytes, the vector length and a shift amount read from a register.

Three scaling modes exist. Unit-stride adds the element step times the access width to the immediate. Element-stride multiplies the immediate by the step. Bit-reverse applies to loads only. It takes a separate 11-bit immediate, multiplies it by the source step with the step's low bits reversed, and shifts the product left by the register amount. When no mode applies, the raw immediate passes through and the replace flag stays low. The result appears one clock after the request, together with a valid strobe.

Top module: `vec_ldst_imm_gen`

## Requirements
- R1: After reset, and until the first request, `out_valid`, `out_replace` and `out_imm` are all zero.
- R2: `out_valid` is high exactly one clock after a cycle in which `in_valid` was high. The outputs carry the result of that request.
- R3: The base immediate is `imm_d` sign-extended to 32 bits when `form_ds` is 0. When `form_ds` is 1 it is `imm_ds` sign-extended and multiplied by 4.
- R4: The element step is `src_step` when `is_store` is 0 and `dst_step` when `is_store` is 1.
- R5: With `mode` = 2'b01 (unit-stride), the result is base + step × `acc_bytes`, modulo 2^32, and `out_replace` is 1.
- R6: With `mode` = 2'b10 (element-stride), the result is base × step, modulo 2^32, and `out_replace` is 1.
- R7: With `mode` = 2'b11 on a load, the result is (sign-extended `imm_rev` × r) << `rev_shamt`, modulo 2^32, and `out_replace` is 1. Here r is `src_step` with its low log2(`vec_len`) bits reversed. `vec_len` is a power of two and the step is below it; `vec_len` = 1 gives r = 0.
- R8: A store with `mode` = 2'b11 gets no bit-reversed scaling. `out_replace` is 0 and the raw immediate passes through as in R10.
- R9: When `out_replace` is 1 and `form_ds` was 1, `out_imm` is the result of R5–R7 shifted right logically by 2.
- R10: With `mode` = 2'b00, `out_replace` is 0. `out_imm` is then the raw immediate: `imm_d` sign-extended, or, for `form_ds` = 1, `imm_ds` sign-extended without the ×4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| is_store | input | 1 | 1 for a store, 0 for a load |
| form_ds | input | 1 | 1 selects the 14-bit word-scaled displacement format |
| mode | input | 2 | 00 none, 01 unit-stride, 10 element-stride, 11 bit-reverse |
| imm_d | input | 16 | 16-bit displacement field |
| imm_ds | input | 14 | 14-bit word displacement field |
| imm_rev | input | 11 | 11-bit immediate used by bit-reverse mode |
| src_step | input | STEP_W | Source element step |
| dst_step | input | STEP_W | Destination element step |
| acc_bytes | input | AB_W | Access width in bytes |
| vec_len | input | STEP_W | Vector length (power of two) |
| rev_shamt | input | SH_W | Left-shift amount from a register |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_imm | output | IMM_W | Effective displacement |
| out_replace | output | 1 | High when `out_imm` replaces the instruction's immediate |

## Verification
Two functions can act on the same request. One pair is the word-format down-shift with bit-reverse scaling. The other is the store rule with bit-reverse mode. The bench provokes the first with a word-format load in bit-reverse mode and a negative immediate. It then checks that the shifted product comes out logically shifted by two, with the top bits cleared. It provokes the second by sending a store in bit-reverse mode, and checks that the raw field passes through with the replace flag low. A behavioural model compares every clock, so back-to-back requests and idle cycles are also judged.

// File: rtl/vec_ldst_imm_gen.sv
module vec_ldst_imm_gen #(
  parameter int STEP_W = 7,
  parameter int AB_W   = 4,
  parameter int SH_W   = 5,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              is_store,
  input  logic              form_ds,
  input  logic [1:0]        mode,
  input  logic [15:0]       imm_d,
  input  logic [13:0]       imm_ds,
  input  logic [10:0]       imm_rev,
  input  logic [STEP_W-1:0] src_step,
  input  logic [STEP_W-1:0] dst_step,
  input  logic [AB_W-1:0]   acc_bytes,
  input  logic [STEP_W-1:0] vec_len,
  input  logic [SH_W-1:0]   rev_shamt,
  output logic              out_valid,
  output logic [IMM_W-1:0]  out_imm,
  output logic              out_replace
);

  localparam logic [1:0] M_NONE = 2'b00;
  localparam logic [1:0] M_UNIT = 2'b01;
  localparam logic [1:0] M_ELEM = 2'b10;
  localparam logic [1:0] M_BREV = 2'b11;

  logic [IMM_W-1:0] d_ext, ds_ext, ds_scaled, rev_ext, base, passthru;
  logic [IMM_W-1:0] step_w, bytes_w, rstep_w, result, shaped;
  logic [STEP_W-1:0] step_sel, rev_step;
  logic              replace;
  int                rev_bits;

  assign d_ext     = {{(IMM_W-16){imm_d[15]}}, imm_d};
  assign ds_ext    = {{(IMM_W-14){imm_ds[13]}}, imm_ds};
  assign ds_scaled = {ds_ext[IMM_W-3:0], 2'b00};
  assign rev_ext   = {{(IMM_W-11){imm_rev[10]}}, imm_rev};
  assign base      = form_ds ? ds_scaled : d_ext;
  assign passthru  = form_ds ? ds_ext : d_ext;

  assign step_sel = is_store ? dst_step : src_step;
  assign step_w   = {{(IMM_W-STEP_W){1'b0}}, step_sel};
  assign bytes_w  = {{(IMM_W-AB_W){1'b0}}, acc_bytes};
  assign rstep_w  = {{(IMM_W-STEP_W){1'b0}}, rev_step};

  always_comb begin
    rev_bits = 0;
    for (int b = 0; b < STEP_W; b++)
      if (vec_len[b]) rev_bits = b;
    rev_step = '0;
    for (int i = 0; i < STEP_W; i++)
      if (i < rev_bits) rev_step[rev_bits-1-i] = src_step[i];
  end

  always_comb begin
    replace = 1'b1;
    result  = passthru;
    case (mode)
      M_UNIT: result = base + step_w * bytes_w;
      M_ELEM: result = base * step_w;
      M_BREV: begin
        if (is_store) replace = 1'b0;
        else          result  = (rev_ext * rstep_w) << rev_shamt;
      end
      default: replace = 1'b0;
    endcase
  end

  assign shaped = (replace && form_ds) ? (result >> 2) : result;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_imm     <= '0;
      out_replace <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_imm     <= shaped;
        out_replace <= replace;
      end
    end
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)));

  a_r10_none_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == M_NONE) |=> !out_replace);

  a_r10_none_value: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == M_NONE && !form_ds) |=> (out_imm[IMM_W-1:15] == {(IMM_W-15){out_imm[15]}}));

  a_r8_store_no_brev: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == M_BREV && is_store) |=> !out_replace);

  a_r9_ds_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && form_ds && mode != M_NONE && !(mode == M_BREV && is_store)) |=> (out_replace && out_imm[IMM_W-1:IMM_W-2] == 2'b00));

  a_r5_unit_replace: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode == M_UNIT || mode == M_ELEM)) |=> out_replace);

endmodule

// File: tb/vec_ldst_imm_gen_tb.sv
module vec_ldst_imm_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, is_store = 0, form_ds = 0;
  logic [1:0] mode = 0;
  logic [15:0] imm_d = 0;
  logic [13:0] imm_ds = 0;
  logic [10:0] imm_rev = 0;
  logic [6:0] src_step = 0, dst_step = 0, vec_len = 1;
  logic [3:0] acc_bytes = 0;
  logic [4:0] rev_shamt = 0;
  logic out_valid, out_replace;
  logic [31:0] out_imm;

  int checks = 0, fails = 0;
  bit exp_v = 0, exp_r = 0;
  logic [31:0] exp_i = 0;
  string exp_tag = "R1";

  always #2 clk = ~clk;

  vec_ldst_imm_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_store(is_store),
    .form_ds(form_ds), .mode(mode), .imm_d(imm_d), .imm_ds(imm_ds),
    .imm_rev(imm_rev), .src_step(src_step), .dst_step(dst_step),
    .acc_bytes(acc_bytes), .vec_len(vec_len), .rev_shamt(rev_shamt),
    .out_valid(out_valid), .out_imm(out_imm), .out_replace(out_replace));

  task automatic check(string tag, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model: returns {replace, value}
  function automatic logic [32:0] model(bit st, bit ds, logic [1:0] m,
      logic [15:0] d, logic [13:0] dsf, logic [10:0] rv, int ss, int dd,
      int ab, int vl, int sh);
    longint base, raw, step, r, res;
    int k;
    bit rep;
    raw  = ds ? longint'($signed(dsf)) : longint'($signed(d));
    base = ds ? raw * 4 : raw;
    step = st ? dd : ss;
    rep  = 1;
    res  = raw;
    if (m == 2'b01) res = base + step * ab;
    else if (m == 2'b10) res = base * step;
    else if (m == 2'b11 && !st) begin
      k = 0;
      while ((1 << k) < vl) k++;
      r = 0;
      for (int i = 0; i < k; i++) if ((ss >> i) & 1) r += (1 << (k - 1 - i));
      res = (longint'($signed(rv)) * r) << sh;
    end else rep = 0;
    res = res & 64'hFFFF_FFFF;
    if (rep && ds) res = res >> 2;
    return {rep, res[31:0]};
  endfunction

  // one clock: compare the previous expectation, then drive the next request
  task automatic step_req(string tag, bit v, bit st, bit ds, logic [1:0] m,
      logic [15:0] d, logic [13:0] dsf, logic [10:0] rv, int ss, int dd,
      int ab, int vl, int sh);
    logic [32:0] e;
    @(negedge clk);
    check({exp_tag, " valid"}, {33'b0, out_valid}, {33'b0, exp_v});
    if (exp_v) check(exp_tag, {1'b0, out_replace, out_imm}, {1'b0, exp_r, exp_i});
    in_valid = v; is_store = st; form_ds = ds; mode = m; imm_d = d;
    imm_ds = dsf; imm_rev = rv; src_step = 7'(ss); dst_step = 7'(dd);
    acc_bytes = 4'(ab); vec_len = 7'(vl); rev_shamt = 5'(sh);
    e = model(st, ds, m, d, dsf, rv, ss, dd, ab, vl, sh);
    exp_v = v; exp_tag = tag;
    if (v) begin exp_r = e[32]; exp_i = e[31:0]; end
  endtask

  initial begin
    #4000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {out_valid, out_replace, out_imm}, 34'b0);
    rst_n = 1'b1;
    // R1 idle after reset, R2 latency
    step_req("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R10 passthrough, D and DS
    step_req("R10", 1, 0, 0, 2'b00, 16'hFFF0, 0, 0, 3, 0, 8, 8, 0);
    step_req("R10", 1, 0, 1, 2'b00, 0, 14'h2001, 0, 3, 0, 8, 8, 0);
    // R5 unit-stride with R3 sign extension, load uses src step (R4)
    step_req("R5", 1, 0, 0, 2'b01, 16'hFFF8, 0, 0, 3, 9, 8, 8, 0);
    // R4 store uses dst step
    step_req("R4", 1, 1, 0, 2'b01, 16'd4, 0, 0, 1, 5, 4, 8, 0);
    // R6 element-stride
    step_req("R6", 1, 0, 0, 2'b10, 16'd100, 0, 0, 5, 0, 0, 8, 0);
    step_req("R6", 1, 1, 0, 2'b10, 16'h8000, 0, 0, 0, 7, 0, 8, 0);
    // R3/R9 DS format with unit-stride
    step_req("R9", 1, 0, 1, 2'b01, 0, 14'd3, 0, 2, 0, 8, 8, 0);
    step_req("R3", 1, 0, 1, 2'b10, 0, 14'h3FFF, 0, 6, 0, 0, 8, 0);
    // R7 bit-reverse loads
    step_req("R7", 1, 0, 0, 2'b11, 0, 0, 11'h7FD, 1, 0, 0, 8, 2);
    step_req("R7", 1, 0, 0, 2'b11, 0, 0, 11'd5, 6, 0, 0, 16, 0);
    step_req("R7", 1, 0, 0, 2'b11, 0, 0, 11'd9, 0, 0, 0, 1, 3);
    step_req("R7", 1, 0, 0, 2'b11, 0, 0, 11'd1, 11, 0, 0, 64, 31);
    // R9 DS + bit-reverse coincide
    step_req("R9", 1, 0, 1, 2'b11, 0, 14'd1, 11'h7FD, 1, 0, 0, 8, 2);
    // R8 store in bit-reverse mode
    step_req("R8", 1, 1, 0, 2'b11, 16'h1234, 0, 11'd7, 3, 3, 8, 8, 1);
    step_req("R8", 1, 1, 1, 2'b11, 0, 14'h2222, 11'd7, 3, 3, 8, 8, 1);
    // R2 gap then request
    step_req("R2", 0, 0, 0, 2'b01, 0, 0, 0, 0, 0, 0, 1, 0);
    step_req("R2", 1, 0, 0, 2'b01, 16'd1, 0, 0, 2, 0, 2, 8, 0);
    step_req("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step_req("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule